// File: doc/BRIEF.md
# Bit-Flag Compare and Branch Unit

This unit executes the compare and jump instruction classes of a 64-bit register machine in which conditions are kept as single bits inside ordinary registers rather than in a dedicated status register. A compare instruction evaluates a condition between two operand values and writes the result into one selected bit of a copy of the destination operand, leaving all other bits as they were. A jump instruction tests one selected bit of an operand, or none at all, and reports whether the branch is taken together with its target address.

The surrounding pipeline hands over a fully formed 64-bit instruction word, raises `issue`, and supplies the three operand values read from the register file. One clock edge later the unit presents a registered write enable and write value for the destination register, or a taken flag and target for the fetch stage. The register file and instruction fetch sit outside the unit. Signalling NaN exceptions sit outside it too.

Top module: `cbu_unit`

## Requirements
- R1: The instruction word is split into fields as follows: bits [63:48] destination register index, [47:32] first source index, [31:16] second source index, [15:8] the bit selector, [7:4] the variant, and [3:0] the opcode. Opcode 4 is compare and opcode 1 is jump.
- R2: While reset is asserted, all outputs are zero. A cycle without `issue` produces all-zero outputs on the next cycle. Results appear exactly one clock edge after the issuing edge.
- R3: A compare raises `wr_en`. It returns `x_val` with the selected bit replaced by the condition result and every other bit unchanged. It never raises `taken`.
- R4: Compare variant 0 sets the bit when `y_val` equals `z_val`.
- R5: Compare variant 1 sets the bit when `y_val` is less than `z_val` as signed two's-complement integers.
- R6: Compare variant 2 sets the bit when `y_val` equals `z_val` as IEEE-754 doubles. Positive and negative zero count as equal. A NaN on either side gives false.
- R7: Compare variant 3 sets the bit when `y_val` is less than `z_val` as IEEE-754 doubles. A NaN on either side gives false.
- R8: A compare whose bit selector is 64 or more writes `x_val` back unchanged, with `wr_en` still raised.
- R9: Jump variant 0 is taken exactly when the selected bit of `y_val` is 1. When taken, `target` equals `x_val`.
- R10: Jump variant 1 is always taken, with `target` equal to `x_val`.
- R11: A variant-0 jump whose bit selector is 64 or more is never taken.
- R12: Compare variants 4 to 15 have a false condition, so the selected bit is cleared. Jump variants 2 to 15 are not taken. Every other opcode leaves all outputs zero. `target` is zero whenever `taken` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue | input | 1 | Instruction word and operands are valid this cycle |
| instr | input | 64 | Instruction word |
| x_val | input | 64 | Destination operand value (compare base, jump target) |
| y_val | input | 64 | First source operand value |
| z_val | input | 64 | Second source operand value |
| wr_en | output | 1 | Destination register write enable |
| wr_data | output | 64 | Value to write to the destination register |
| taken | output | 1 | Branch taken |
| target | output | 64 | Branch target address |

## Verification
The hardest cases to reach are the floating-point corners. These are signed zeros, infinities, subnormals and NaN, where the raw bit patterns order differently from the values they encode. The bench feeds every ordered pair from a set of special doubles through both float compares. It derives expected results from real-number comparison of the same bit patterns, not from bit manipulation. Out-of-range bit selectors are reached by sweeping the selector across all 256 codes for every jump variant and for compares with both true and false conditions.

// File: rtl/cbu_pkg.sv
package cbu_pkg;
    localparam int FIELD_W = 16;
    localparam int SEL_W   = 8;
    localparam int VAR_W   = 4;
    localparam int OPC_W   = 4;

    localparam logic [OPC_W-1:0] OPC_JUMP = 4'd1;
    localparam logic [OPC_W-1:0] OPC_CMP  = 4'd4;

    localparam logic [VAR_W-1:0] CV_INT_EQ = 4'd0;
    localparam logic [VAR_W-1:0] CV_INT_LT = 4'd1;
    localparam logic [VAR_W-1:0] CV_FP_EQ  = 4'd2;
    localparam logic [VAR_W-1:0] CV_FP_LT  = 4'd3;

    localparam logic [VAR_W-1:0] JV_ON_BIT = 4'd0;
    localparam logic [VAR_W-1:0] JV_ALWAYS = 4'd1;

    typedef struct packed {
        logic [FIELD_W-1:0] dst_idx;
        logic [FIELD_W-1:0] src_a_idx;
        logic [FIELD_W-1:0] src_b_idx;
        logic [SEL_W-1:0]   bit_sel;
        logic [VAR_W-1:0]   variant;
        logic [OPC_W-1:0]   opcode;
    } instr_t;
endpackage

// File: rtl/cbu_decode.sv
module cbu_decode
    import cbu_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [4*FIELD_W-1:0] instr,
    output logic [OPC_W-1:0]     opcode,
    output logic [VAR_W-1:0]     variant,
    output logic [DATA_W-1:0]    sel_mask
);
    instr_t fields;

    assign fields  = instr_t'(instr);
    assign opcode  = fields.opcode;
    assign variant = fields.variant;

    // one-hot mask of the selected bit; all zero when the selector is out of range
    for (genvar b = 0; b < DATA_W; b++) begin : g_mask
        assign sel_mask[b] = (fields.bit_sel == SEL_W'(b));
    end
endmodule

// File: rtl/cbu_int_cmp.sv
module cbu_int_cmp #(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic              eq,
    output logic              lt
);
    assign eq = (a == b);
    assign lt = ($signed(a) < $signed(b));
endmodule

// File: rtl/cbu_fp_cmp.sv
module cbu_fp_cmp #(
    parameter int EXP_W = 11,
    parameter int MAN_W = 52
) (
    input  logic [EXP_W+MAN_W:0] a,
    input  logic [EXP_W+MAN_W:0] b,
    output logic                 eq,
    output logic                 lt
);
    localparam int MAG_W = EXP_W + MAN_W;

    logic             a_nan, b_nan, any_nan, both_zero;
    logic             a_neg, b_neg;
    logic [MAG_W-1:0] a_mag, b_mag;

    assign a_neg = a[MAG_W];
    assign b_neg = b[MAG_W];
    assign a_mag = a[MAG_W-1:0];
    assign b_mag = b[MAG_W-1:0];

    assign a_nan     = (&a[MAG_W-1:MAN_W]) && (|a[MAN_W-1:0]);
    assign b_nan     = (&b[MAG_W-1:MAN_W]) && (|b[MAN_W-1:0]);
    assign any_nan   = a_nan || b_nan;
    assign both_zero = (a_mag == '0) && (b_mag == '0);

    always_comb begin
        eq = 1'b0;
        lt = 1'b0;
        if (!any_nan) begin
            eq = both_zero || (a == b);
            if (!both_zero) begin
                case ({a_neg, b_neg})
                    2'b10:   lt = 1'b1;
                    2'b01:   lt = 1'b0;
                    2'b00:   lt = (a_mag < b_mag);
                    default: lt = (a_mag > b_mag);
                endcase
            end
        end
    end
endmodule

// File: rtl/cbu_unit.sv
module cbu_unit
    import cbu_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int EXP_W  = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic [63:0]       instr,
    input  logic [DATA_W-1:0] x_val,
    input  logic [DATA_W-1:0] y_val,
    input  logic [DATA_W-1:0] z_val,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_data,
    output logic              taken,
    output logic [DATA_W-1:0] target
);
    localparam int MAN_W = DATA_W - EXP_W - 1;

    typedef struct packed {
        logic              wr_en;
        logic [DATA_W-1:0] wr_data;
        logic              taken;
        logic [DATA_W-1:0] target;
    } result_t;

    result_t state_d, state_q;

    logic [OPC_W-1:0]  opcode;
    logic [VAR_W-1:0]  variant;
    logic [DATA_W-1:0] sel_mask;
    logic              int_eq, int_lt, fp_eq, fp_lt;
    logic              cond;

    cbu_decode #(.DATA_W(DATA_W)) u_decode (
        .instr    (instr),
        .opcode   (opcode),
        .variant  (variant),
        .sel_mask (sel_mask)
    );

    cbu_int_cmp #(.DATA_W(DATA_W)) u_int_cmp (
        .a  (y_val),
        .b  (z_val),
        .eq (int_eq),
        .lt (int_lt)
    );

    cbu_fp_cmp #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_fp_cmp (
        .a  (y_val),
        .b  (z_val),
        .eq (fp_eq),
        .lt (fp_lt)
    );

    always_comb begin
        case (variant)
            CV_INT_EQ: cond = int_eq;
            CV_INT_LT: cond = int_lt;
            CV_FP_EQ:  cond = fp_eq;
            CV_FP_LT:  cond = fp_lt;
            default:   cond = 1'b0;
        endcase
    end

    always_comb begin
        state_d = '0;
        if (issue) begin
            case (opcode)
                OPC_CMP: begin
                    state_d.wr_en   = 1'b1;
                    state_d.wr_data = (x_val & ~sel_mask) | (cond ? sel_mask : '0);
                end
                OPC_JUMP: begin
                    state_d.taken = ((variant == JV_ON_BIT) && (|(y_val & sel_mask)))
                                 || (variant == JV_ALWAYS);
                    state_d.target = state_d.taken ? x_val : '0;
                end
                default: state_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign wr_en   = state_q.wr_en;
    assign wr_data = state_q.wr_data;
    assign taken   = state_q.taken;
    assign target  = state_q.target;
endmodule

// File: rtl/cbu_unit_chk.sv
module cbu_unit_chk #(
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              issue,
    input logic [63:0]       instr,
    input logic [DATA_W-1:0] x_val,
    input logic [DATA_W-1:0] y_val,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic              taken,
    input logic [DATA_W-1:0] target
);
    logic       is_cmp, is_jmp, sel_hi;
    logic [3:0] var_f;

    assign is_cmp = issue && (instr[3:0] == 4'd4);
    assign is_jmp = issue && (instr[3:0] == 4'd1);
    assign var_f  = instr[7:4];
    assign sel_hi = (instr[15:8] >= 8'd64);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !issue |=> (!wr_en && !taken)); // R2

    AST_CMP_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
        is_cmp |=> (wr_en && !taken)); // R3

    AST_CMP_WIDE_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (is_cmp && sel_hi) |=> (wr_data == $past(x_val))); // R8

    AST_JMP_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (is_jmp && var_f == 4'd1) |=> (taken && !wr_en && target == $past(x_val))); // R10

    AST_JMP_WIDE_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (is_jmp && var_f == 4'd0 && sel_hi) |=> !taken); // R11

    AST_TARGET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !taken |-> (target == '0)); // R12

    AST_JMP_ON_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (is_jmp && var_f == 4'd0 && !sel_hi) |=> (taken == $past(y_val[instr[13:8]]))); // R9
endmodule

bind cbu_unit cbu_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .issue   (issue),
    .instr   (instr),
    .x_val   (x_val),
    .y_val   (y_val),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .taken   (taken),
    .target  (target)
);

// File: tb/cbu_unit_bench.sv
`timescale 1ns/1ps
module cbu_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue = 1'b0;
    logic [63:0] instr = '0, x_val = '0, y_val = '0, z_val = '0;
    logic        wr_en, taken;
    logic [63:0] wr_data, target;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #10 clk = ~clk;

    cbu_unit u_cbu_unit (
        .clk(clk), .rst_n(rst_n), .issue(issue), .instr(instr),
        .x_val(x_val), .y_val(y_val), .z_val(z_val),
        .wr_en(wr_en), .wr_data(wr_data), .taken(taken), .target(target)
    );

    function automatic logic [63:0] mk(input logic [7:0] sel, input logic [3:0] v, input logic [3:0] op);
        return {16'h0003, 16'h0001, 16'h0002, sel, v, op};
    endfunction

    task automatic expect_out(input string req, input logic ew, input logic [63:0] ed,
                              input logic et, input logic [63:0] etg);
        n_checks++;
        if (wr_en !== ew || wr_data !== ed || taken !== et || target !== etg) begin
            n_fail++;
            $display("FAIL %s: got we=%0b data=%h tk=%0b tgt=%h exp we=%0b data=%h tk=%0b tgt=%h",
                     req, wr_en, wr_data, taken, target, ew, ed, et, etg);
        end
    endtask

    // issue one op at a negedge; check at the following negedge
    task automatic run_op(input string req, input logic [63:0] ins,
                          input logic [63:0] x, input logic [63:0] y, input logic [63:0] z);
        logic [7:0]  sel = ins[15:8];
        logic [3:0]  v   = ins[7:4];
        logic [3:0]  op  = ins[3:0];
        logic        c   = 1'b0;
        logic        ew = 0, et = 0;
        logic [63:0] ed = '0, etg = '0;
        case (v)
            4'd0: c = (y == z);
            4'd1: c = ($signed(y) < $signed(z));
            4'd2: c = ($bitstoreal(y) == $bitstoreal(z));
            4'd3: c = ($bitstoreal(y) < $bitstoreal(z));
            default: c = 1'b0;
        endcase
        if (op == 4'd4) begin
            ew = 1;
            ed = x;
            if (sel < 64) ed[sel[5:0]] = c;
        end else if (op == 4'd1) begin
            et = (v == 4'd1) || (v == 4'd0 && sel < 64 && y[sel[5:0]]);
            etg = et ? x : '0;
        end
        issue = 1; instr = ins; x_val = x; y_val = y; z_val = z;
        @(posedge clk);
        @(negedge clk);
        expect_out(req, ew, ed, et, etg);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [63:0] ints [7];
        logic [63:0] fps  [11];
        ints = '{64'd0, 64'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h7FFF_FFFF_FFFF_FFFF,
                 64'h8000_0000_0000_0000, 64'd5, 64'hFFFF_FFFF_FFFF_FFFB};
        fps  = '{64'h0000_0000_0000_0000, 64'h8000_0000_0000_0000, 64'h3FF0_0000_0000_0000,
                 64'hBFF0_0000_0000_0000, 64'h4004_0000_0000_0000, 64'hC008_0000_0000_0000,
                 64'h7FF0_0000_0000_0000, 64'hFFF0_0000_0000_0000, 64'h7FF8_0000_0000_0001,
                 64'h0000_0000_0000_0001, 64'h8000_0000_0000_0001};

        // R2: reset state
        repeat (3) @(negedge clk);
        instr = mk(8'd3, 4'd1, 4'd1); issue = 1; x_val = 64'h1234;
        @(negedge clk);
        expect_out("R2 reset", 0, '0, 0, '0);
        issue = 0; rst_n = 1;
        @(posedge clk); @(negedge clk);
        expect_out("R2 idle after reset", 0, '0, 0, '0);

        // R1 R3 R4 R8: compare with every selector code, condition true and false
        for (int s = 0; s < 256; s++) begin
            run_op("R1 R3 R4 R8 cmp eq true", mk(s[7:0], 4'd0, 4'd4),
                   64'hA5A5_0F0F_3C3C_9669 ^ {8{s[7:0]}}, 64'd77, 64'd77);
            run_op("R3 R4 R8 cmp eq false", mk(s[7:0], 4'd0, 4'd4),
                   64'hFFFF_FFFF_FFFF_FFFF, 64'd77, 64'd78);
        end

        // R4 R5: integer pairs
        for (int i = 0; i < 7; i++)
            for (int j = 0; j < 7; j++) begin
                run_op("R4 int eq", mk(8'(i * 9), 4'd0, 4'd4), 64'h0F0F_0F0F_0F0F_0F0F, ints[i], ints[j]);
                run_op("R5 int lt signed", mk(8'(63 - i * 9), 4'd1, 4'd4), 64'hF0F0_F0F0_F0F0_F0F0, ints[i], ints[j]);
            end

        // R6 R7: float special-value pairs
        for (int i = 0; i < 11; i++)
            for (int j = 0; j < 11; j++) begin
                run_op("R6 fp eq", mk(8'd63, 4'd2, 4'd4), 64'h5555_5555_5555_5555, fps[i], fps[j]);
                run_op("R7 fp lt", mk(8'd0, 4'd3, 4'd4), 64'hAAAA_AAAA_AAAA_AAAA, fps[i], fps[j]);
            end

        // R12: undefined compare variants clear the bit
        for (int v = 4; v < 16; v++)
            run_op("R12 cmp other variant", mk(8'd12, 4'(v), 4'd4), '1, 64'd3, 64'd3);

        // R9 R10 R11 R12: jumps across selector codes and variants
        for (int v = 0; v < 16; v++)
            for (int s = 0; s < 256; s++)
                run_op("R9 R10 R11 R12 jump", mk(s[7:0], 4'(v), 4'd1),
                       64'h0000_0000_0002_0000 + 64'(s), 64'hC3A5_5A3C_0F01_8E71 ^ (64'(v) << 60), 64'd0);

        // R12: other opcodes produce nothing
        for (int op = 0; op < 16; op++)
            for (int v = 0; v < 4; v++)
                if (op != 1 && op != 4)
                    run_op("R12 other opcode", mk(8'd5, 4'(v), 4'(op)), 64'hDEAD, '1, '1);

        // R2: dropping issue clears outputs on the next cycle
        issue = 0; instr = mk(8'd1, 4'd1, 4'd1);
        @(posedge clk); @(negedge clk);
        expect_out("R2 no issue", 0, '0, 0, '0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule